// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers seven interrupt sources of a parallel I/O port controller into one flag register. There are two timer time-out pulses, a shift-complete pulse and active edges on four handshake control lines: two on side A and two on side B. Each source has a matching enable bit. When any flag is set together with its enable, a combined active-low interrupt line asserts. The block also holds the peripheral control register. That register selects which edge is active on each control line, and whether the second line of each side is an input at all.

Flags are cleared in two ways. The first is by writing ones to the flag register. The second is as a side effect of touching other registers: the port A and port B data registers and the shift register. The second line of each side has an "independent" input mode in which the port access does not clear its flag. There is a second port A offset that gives access with no side effects at all. Readback of the flag register carries a summary bit in bit 7. The interrupt pin follows that summary one clock later.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all flags, all enables and the control register are zero, `flag_rd` reads 0x00 and `irq_n` is high. All four control lines are taken to have been low at reset.
- R2: A high `tmr1_evt`, `tmr2_evt` or `shift_done` on a clock edge sets flag bit 6, bit 5 or bit 2 respectively at that edge. A set always wins over a clear requested in the same cycle.
- R3: Control register bit 0 selects the active edge of `ca1_in` (0 = falling, 1 = rising), which sets flag bit 1. Control register bit 4 does the same for `cb1_in`, which sets flag bit 4. An edge is a change of the line between two consecutive clock edges.
- R4: Control register bits 3:1 (for `ca2_in`, flag bit 0) and bits 7:5 (for `cb2_in`, flag bit 3) act as follows: 000 = falling edge, 001 = falling edge, independent, 010 = rising edge, 011 = rising edge, independent. Values 1xx are output modes and never set the flag.
- R5: A read or write at offset 0x0 clears flag bit 4. It also clears flag bit 3 unless the bits 7:5 field is 001 or 011.
- R6: A read or write at offset 0x1 clears flag bit 1. It also clears flag bit 0 unless the bits 3:1 field is 001 or 011. An access at offset 0xF changes no flag.
- R7: A read or write at offset 0xA clears flag bit 2.
- R8: A write at offset 0xD clears each of flag bits 6:0 whose data bit is 1. A read at 0xD changes nothing.
- R9: A write at offset 0xE sets the enables selected by ones in data bits 6:0 when data bit 7 is 1, and clears them when data bit 7 is 0.
- R10: `flag_rd[7]` is 1 exactly when some flag bit is set together with its enable. It changes in the same cycle as the flags.
- R11: `irq_n` equals the inverse of `flag_rd[7]` from one clock earlier, both when asserting and when releasing.
- R12: A write at offset 0xC loads the control register from `wdata`. The new field values govern edges from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr1_evt | input | 1 | Timer 1 time-out pulse |
| tmr2_evt | input | 1 | Timer 2 time-out pulse |
| shift_done | input | 1 | Shift register finished eight shifts |
| ca1_in | input | 1 | Side A first control line |
| ca2_in | input | 1 | Side A second control line |
| cb1_in | input | 1 | Side B first control line |
| cb2_in | input | 1 | Side B second control line |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register offset |
| wdata | input | 8 | Write data |
| flag_rd | output | 8 | Flag register readback, bit 7 = summary |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Flag changes, summary bit changes and control or enable register updates all take effect at the clock edge that samples the stimulus. The interrupt pin changes one edge after the summary. The bench drives each stimulus after a falling edge and lets one rising edge pass. At that rising edge its model advances on the same inputs. At the next falling edge it compares `flag_rd` with the new model state and compares `irq_n` with the summary the model held before that edge. The model tracks the previous line levels in the same way, so an edge that is due on a given clock is expected there and not a cycle early.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int AW = 4,
  parameter logic [AW-1:0] OFS_PB   = 'h0,
  parameter logic [AW-1:0] OFS_PA   = 'h1,
  parameter logic [AW-1:0] OFS_SR   = 'hA,
  parameter logic [AW-1:0] OFS_CTL  = 'hC,
  parameter logic [AW-1:0] OFS_FLG  = 'hD,
  parameter logic [AW-1:0] OFS_ENA  = 'hE,
  parameter logic [AW-1:0] OFS_PANH = 'hF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr1_evt,
  input  logic          tmr2_evt,
  input  logic          shift_done,
  input  logic          ca1_in,
  input  logic          ca2_in,
  input  logic          cb1_in,
  input  logic          cb2_in,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    flag_rd,
  output logic          irq_n
);

  localparam int NSRC = 7;

  logic [NSRC-1:0] flag_q, ena_q, set_v, clr_v, flag_d;
  logic [7:0]      ctl_q;
  logic [3:0]      line_q;
  logic            irq_q;

  function automatic logic act_edge(input logic rising, input logic prv, input logic cur);
    return rising ? (!prv && cur) : (prv && !cur);
  endfunction

  wire acc      = rd_en || wr_en;
  wire hit_pb   = acc && (addr == OFS_PB);
  wire hit_pa   = acc && (addr == OFS_PA);
  wire hit_sr   = acc && (addr == OFS_SR);
  wire wr_ctl   = wr_en && (addr == OFS_CTL);
  wire wr_flg   = wr_en && (addr == OFS_FLG);
  wire wr_ena   = wr_en && (addr == OFS_ENA);

  wire [2:0] ca2_f = ctl_q[3:1];
  wire [2:0] cb2_f = ctl_q[7:5];
  wire ca2_ind  = !ca2_f[2] && ca2_f[0];
  wire cb2_ind  = !cb2_f[2] && cb2_f[0];

  wire e_ca1 = act_edge(ctl_q[0], line_q[0], ca1_in);
  wire e_ca2 = !ca2_f[2] && act_edge(ca2_f[1], line_q[1], ca2_in);
  wire e_cb1 = act_edge(ctl_q[4], line_q[2], cb1_in);
  wire e_cb2 = !cb2_f[2] && act_edge(cb2_f[1], line_q[3], cb2_in);

  assign set_v = {tmr1_evt, tmr2_evt, e_cb1, e_cb2, shift_done, e_ca1, e_ca2};

  always_comb begin
    clr_v    = wr_flg ? wdata[NSRC-1:0] : '0;
    clr_v[4] = clr_v[4] | hit_pb;
    clr_v[3] = clr_v[3] | (hit_pb && !cb2_ind);
    clr_v[2] = clr_v[2] | hit_sr;
    clr_v[1] = clr_v[1] | hit_pa;
    clr_v[0] = clr_v[0] | (hit_pa && !ca2_ind);
  end

  assign flag_d = (flag_q & ~clr_v) | set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      ena_q  <= '0;
      ctl_q  <= '0;
      line_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      line_q <= {cb2_in, cb1_in, ca2_in, ca1_in};
      irq_q  <= |(flag_q & ena_q);
      if (wr_ctl) ctl_q <= wdata;
      if (wr_ena) ena_q <= wdata[7] ? (ena_q | wdata[NSRC-1:0]) : (ena_q & ~wdata[NSRC-1:0]);
    end
  end

  assign flag_rd = {|(flag_q & ena_q), flag_q};
  assign irq_n   = !irq_q;

endmodule

module irq_flag_ctrl_chk #(
  parameter int AW = 4,
  parameter logic [AW-1:0] OFS_SR  = 'hA,
  parameter logic [AW-1:0] OFS_FLG = 'hD
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmr1_evt,
  input logic          tmr2_evt,
  input logic          shift_done,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [7:0]    wdata,
  input logic [7:0]    flag_rd,
  input logic          irq_n
);
  logic pv;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pv <= 1'b0; else pv <= 1'b1;

  p_irq_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (irq_n == !$past(flag_rd[7])));
  p_t1_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr1_evt |=> flag_rd[6]);
  p_sr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && addr == OFS_SR && !shift_done) |=> !flag_rd[2]);
  p_flg_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_FLG && wdata[5] && !tmr2_evt) |=> !flag_rd[5]);
  p_summary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd[6:0] == 7'd0) |-> !flag_rd[7]);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.AW(AW), .OFS_SR(OFS_SR), .OFS_FLG(OFS_FLG)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr1_evt(tmr1_evt), .tmr2_evt(tmr2_evt),
  .shift_done(shift_done), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .flag_rd(flag_rd), .irq_n(irq_n));

// File: tb/sim_irq_flag_ctrl.sv
`timescale 1ns/1ps
module sim_irq_flag_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr1_evt, tmr2_evt, shift_done;
  logic ca1_in, ca2_in, cb1_in, cb2_in;
  logic rd_en, wr_en;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] flag_rd;
  logic irq_n;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [6:0] m_flag, m_en;
  logic [7:0] m_ctl;
  logic [3:0] m_line;
  logic       m_sum_prev;

  always #5 clk = ~clk;

  irq_flag_ctrl u0 (.clk(clk), .rst_n(rst_n), .tmr1_evt(tmr1_evt), .tmr2_evt(tmr2_evt),
    .shift_done(shift_done), .ca1_in(ca1_in), .ca2_in(ca2_in), .cb1_in(cb1_in), .cb2_in(cb2_in),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .flag_rd(flag_rd), .irq_n(irq_n));

  function automatic logic edg(input logic rise, input logic p, input logic c);
    return rise ? (!p && c) : (p && !c);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [6:0] s, c;
    logic acc;
    logic ind_a, ind_b;
    acc   = rd_en | wr_en;
    ind_a = (m_ctl[3:1] == 3'b001) || (m_ctl[3:1] == 3'b011);
    ind_b = (m_ctl[7:5] == 3'b001) || (m_ctl[7:5] == 3'b011);
    s = '0; c = '0;
    s[6] = tmr1_evt; s[5] = tmr2_evt; s[2] = shift_done;
    s[1] = edg(m_ctl[0], m_line[0], ca1_in);
    s[0] = !m_ctl[3] && edg(m_ctl[2], m_line[1], ca2_in);
    s[4] = edg(m_ctl[4], m_line[2], cb1_in);
    s[3] = !m_ctl[7] && edg(m_ctl[6], m_line[3], cb2_in);
    if (wr_en && addr == 4'hD) c = wdata[6:0];
    if (acc && addr == 4'h0) begin c[4] = 1'b1; if (!ind_b) c[3] = 1'b1; end
    if (acc && addr == 4'h1) begin c[1] = 1'b1; if (!ind_a) c[0] = 1'b1; end
    if (acc && addr == 4'hA) c[2] = 1'b1;
    m_sum_prev = |(m_flag & m_en);
    m_flag = (m_flag & ~c) | s;
    if (wr_en && addr == 4'hC) m_ctl = wdata;
    if (wr_en && addr == 4'hE) m_en = wdata[7] ? (m_en | wdata[6:0]) : (m_en & ~wdata[6:0]);
    m_line = {cb2_in, cb1_in, ca2_in, ca1_in};
  endtask

  task automatic idle();
    tmr1_evt = 0; tmr2_evt = 0; shift_done = 0; rd_en = 0; wr_en = 0; addr = 4'h3; wdata = 8'h00;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, flag_rd, {|(m_flag & m_en), m_flag});
    chk("R11", {7'd0, irq_n}, {7'd0, !m_sum_prev});
    idle();
  endtask

  task automatic acc_w(input logic [3:0] a, input logic [7:0] d, input string tag);
    wr_en = 1; addr = a; wdata = d; step(tag);
  endtask

  task automatic acc_r(input logic [3:0] a, input string tag);
    rd_en = 1; addr = a; step(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    ca1_in = 0; ca2_in = 0; cb1_in = 0; cb2_in = 0;
    m_flag = '0; m_en = '0; m_ctl = '0; m_line = '0; m_sum_prev = 0;
    repeat (3) @(negedge clk);
    chk("R1", flag_rd, 8'h00);
    chk("R1", {7'd0, irq_n}, 8'h01);
    rst_n = 1;

    acc_w(4'hE, 8'hC0, "R9");
    tmr1_evt = 1; step("R2");
    chk("R10", flag_rd, 8'hC0);
    step("R11");
    chk("R11", {7'd0, irq_n}, 8'h00);
    acc_r(4'hD, "R8");
    acc_w(4'hD, 8'h40, "R8");
    step("R11");
    tmr1_evt = 1; wr_en = 1; addr = 4'hD; wdata = 8'h40; step("R2");

    acc_w(4'hC, 8'h02, "R12");
    ca2_in = 1; step("R4");
    ca2_in = 0; step("R4");
    ca1_in = 1; step("R3");
    ca1_in = 0; step("R3");
    acc_r(4'hF, "R6");
    acc_r(4'h1, "R6");
    acc_w(4'hC, 8'h00, "R12");
    ca2_in = 1; step("R4");
    ca2_in = 0; step("R4");
    acc_w(4'h1, 8'h55, "R6");

    acc_w(4'hC, 8'h70, "R12");
    cb1_in = 1; step("R3");
    cb2_in = 1; step("R4");
    acc_w(4'h0, 8'h00, "R5");
    acc_w(4'hC, 8'h00, "R12");
    cb2_in = 0; step("R4");
    acc_r(4'h0, "R5");
    acc_w(4'hC, 8'h80, "R12");
    cb2_in = 1; step("R4");
    cb2_in = 0; step("R4");

    shift_done = 1; step("R2");
    acc_w(4'hE, 8'h84, "R9");
    acc_r(4'hA, "R7");
    acc_w(4'hE, 8'h04, "R9");

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      tmr1_evt   = ($urandom_range(0, 9) == 0);
      tmr2_evt   = ($urandom_range(0, 9) == 0);
      shift_done = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 3) == 0) ca1_in = ~ca1_in;
      if ($urandom_range(0, 3) == 0) ca2_in = ~ca2_in;
      if ($urandom_range(0, 3) == 0) cb1_in = ~cb1_in;
      if ($urandom_range(0, 3) == 0) cb2_in = ~cb2_in;
      wdata = 8'($urandom);
      if (r < 30) begin
        rd_en = 1; addr = 4'($urandom);
      end else if (r < 60) begin
        wr_en = 1;
        case ($urandom_range(0, 6))
          0: addr = 4'h0; 1: addr = 4'h1; 2: addr = 4'hA; 3: addr = 4'hC;
          4: addr = 4'hD; 5: addr = 4'hE; default: addr = 4'hF;
        endcase
      end
      step("R10");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule